// File: doc/BRIEF.md
# Watchdog Reset Router

This block sits on the always-on power-management side, between a watchdog timer's reset request and the system reset controller. It decides whether a watchdog reset request reaches the system. Three small control registers, reached through a simple word-addressed register bus with byte enables, govern that decision. A gating bit lets the request through or holds it back, and a parameter chooses whether a set bit means "block" or "pass". An auto-suppress bit holds the request back while the associated processor is itself held in reset. A counter-run bit drives an output that the watchdog counter needs before it will count.

A sticky status bit records that a routed watchdog reset took place. The block is reset only by power-on reset, so this bit survives the system reset it reports. Software clears it by writing a one to it. Bit positions, bus widths and the gating polarity are all parameters. The width of the reset pulse and every other reset source belong to the reset controller.

Register map (word index on `bus_addr`): 0 = gating register, 1 = auto-suppress register, 2 = counter-run register, 3 = status register. Indices 4 and above are unmapped.

Top module: `wdt_reset_router`

## Requirements
- R1: After power-on reset, the gating register reads with only bit GATE_BIT set when GATE_INV=0, and reads all zero when GATE_INV=1, so in both cases the request is blocked. The status register reads 0, `cnt_enable` is 0 and `sys_wdt_rst` is 0.
- R2: With GATE_INV=0, `sys_wdt_rst` goes high one clock after `wdt_req` is sampled high, and only when bit GATE_BIT of the gating register is 0. When that bit is 1 the output stays low.
- R3: With GATE_INV=1 the meaning of the gating bit is inverted: the request passes only when bit GATE_BIT is 1.
- R4: When bit AUTO_BIT of the auto-suppress register is 1 and `cpu_in_reset` is high, the request is blocked. If either of the two is low, the auto-suppress logic does not block the request.
- R5: `cnt_enable` equals bit CNT_BIT of the counter-run register and changes one clock after a write to that register.
- R6: Registers 0 to 2 hold all DATA_W bits and read them back. A write changes only the bytes whose `bus_be` bit is set. All other bits keep their value.
- R7: A routed reset sets status bit STAT_BIT (register 3) in the same clock edge that raises `sys_wdt_rst`. The bit stays set after the request goes away. All other status bits read 0.
- R8: Writing register 3 clears the status bit only when bit STAT_BIT of the write data is 1 and the byte enable for byte STAT_BIT/8 is set. A write of 0, or a write with that byte disabled, leaves the bit unchanged.
- R9: If a routed reset and a clearing write occur in the same cycle, the status bit ends up set.
- R10: Writes to unmapped word indices change no register, and reads from them return 0.
- R11: Read data appears on `bus_rdata` one clock after a read is sampled and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| por_n | input | 1 | Active-low asynchronous power-on reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word index of the register |
| bus_be | input | DATA_W/8 | Byte enables for writes |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| wdt_req | input | 1 | Reset request from the watchdog |
| cpu_in_reset | input | 1 | High while the associated processor is held in reset |
| cnt_enable | output | 1 | Run permission for the watchdog counter |
| sys_wdt_rst | output | 1 | Routed watchdog reset to the reset controller |

## Verification
On every cycle, the assertions check that the routed reset never appears without a request the cycle before, never passes a gating bit of the wrong polarity, and never passes while auto-suppress and processor reset coincide. They also check that the status bit is set whenever the routed reset is, that it only falls after a clearing write, and that the control outputs move only after a bus write. Only the bench scenarios can show the register read-back values after partial-byte writes, the reset values of both polarities, the byte-enable qualification of the clear, the set-over-clear priority, and that unmapped indices stay inert.

// File: rtl/wdr_pkg.sv
package wdr_pkg;

    localparam int unsigned WDR_IDX_W = 2;

    typedef enum logic [WDR_IDX_W-1:0] {
        REG_GATE = 2'd0,
        REG_AUTO = 2'd1,
        REG_CNT  = 2'd2,
        REG_STAT = 2'd3
    } wdr_reg_e;

endpackage

// File: rtl/wdr_regfile.sv
module wdr_regfile
    import wdr_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 3,
    parameter int unsigned GATE_BIT = 8,
    parameter int unsigned AUTO_BIT = 8,
    parameter int unsigned CNT_BIT  = 4,
    parameter int unsigned STAT_BIT = 23,
    parameter bit          GATE_INV = 1'b0
) (
    input  logic                 clk,
    input  logic                 por_n,
    input  logic                 sel_i,
    input  logic                 wr_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [DATA_W/8-1:0]  be_i,
    input  logic [DATA_W-1:0]    wdata_i,
    input  logic                 stat_i,
    output logic [DATA_W-1:0]    rdata_o,
    output logic                 gate_bit_o,
    output logic                 auto_bit_o,
    output logic                 cnt_o,
    output logic                 clr_o
);

    localparam int unsigned BE_W = DATA_W / 8;
    localparam logic [DATA_W-1:0] ONE_W = {{(DATA_W-1){1'b0}}, 1'b1};
    localparam logic [DATA_W-1:0] GATE_RST = GATE_INV ? '0 : (ONE_W << GATE_BIT);

    typedef struct packed {
        logic [DATA_W-1:0] gate;
        logic [DATA_W-1:0] autod;
        logic [DATA_W-1:0] cnt;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t d, q;

    logic [DATA_W-1:0] bmask;
    logic [DATA_W-1:0] stat_word;
    logic              in_range;
    logic              wr_en;
    wdr_reg_e          idx;

    for (genvar b = 0; b < BE_W; b++) begin : g_bmask
        assign bmask[b*8 +: 8] = {8{be_i[b]}};
    end

    always_comb begin
        stat_word           = '0;
        stat_word[STAT_BIT] = stat_i;
        in_range = (addr_i >> WDR_IDX_W) == '0;
        idx      = wdr_reg_e'(addr_i[WDR_IDX_W-1:0]);
        wr_en    = sel_i && wr_i && in_range;
        clr_o    = wr_en && (idx == REG_STAT) && be_i[STAT_BIT/8] && wdata_i[STAT_BIT];

        d = q;
        if (wr_en) begin
            unique case (idx)
                REG_GATE: d.gate  = (q.gate  & ~bmask) | (wdata_i & bmask);
                REG_AUTO: d.autod = (q.autod & ~bmask) | (wdata_i & bmask);
                REG_CNT:  d.cnt   = (q.cnt   & ~bmask) | (wdata_i & bmask);
                default:  ;
            endcase
        end
        if (sel_i && !wr_i) begin
            if (!in_range) begin
                d.rdata = '0;
            end else begin
                unique case (idx)
                    REG_GATE: d.rdata = q.gate;
                    REG_AUTO: d.rdata = q.autod;
                    REG_CNT:  d.rdata = q.cnt;
                    default:  d.rdata = stat_word;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            q.gate  <= GATE_RST;
            q.autod <= '0;
            q.cnt   <= '0;
            q.rdata <= '0;
        end else begin
            q <= d;
        end
    end

    assign rdata_o    = q.rdata;
    assign gate_bit_o = q.gate[GATE_BIT];
    assign auto_bit_o = q.autod[AUTO_BIT];
    assign cnt_o      = q.cnt[CNT_BIT];

    // R5: the counter-run output only moves after a bus write
    assert_cnt_quiet_R5: assert property (@(posedge clk) disable iff (!por_n)
        !$past(sel_i && wr_i) |-> $stable(cnt_o));

    // R6: the gating and auto-suppress bits only move after a bus write
    assert_ctrl_quiet_R6: assert property (@(posedge clk) disable iff (!por_n)
        !$past(sel_i && wr_i) |-> ($stable(gate_bit_o) && $stable(auto_bit_o)));

endmodule

// File: rtl/wdr_gate.sv
module wdr_gate #(
    parameter bit GATE_INV = 1'b0
) (
    input  logic clk,
    input  logic por_n,
    input  logic req_i,
    input  logic cpu_rst_i,
    input  logic gate_bit_i,
    input  logic auto_bit_i,
    input  logic clr_i,
    output logic rst_o,
    output logic stat_o
);

    typedef struct packed {
        logic rst;
        logic stat;
    } gate_t;

    gate_t d, q;
    logic  eff_en;
    logic  pass;

    if (GATE_INV) begin : g_pass_when_set
        assign eff_en = gate_bit_i;
    end else begin : g_block_when_set
        assign eff_en = !gate_bit_i;
    end

    always_comb begin
        pass   = req_i && eff_en && !(auto_bit_i && cpu_rst_i);
        d.rst  = pass;
        d.stat = pass || (q.stat && !clr_i);
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rst_o  = q.rst;
    assign stat_o = q.stat;

    // R2: no routed reset without a request on the previous cycle
    assert_req_needed_R2: assert property (@(posedge clk) disable iff (!por_n)
        rst_o |-> $past(req_i));

    // R3: a routed reset implies the gating bit had its passing value
    assert_polarity_R3: assert property (@(posedge clk) disable iff (!por_n)
        rst_o |-> ($past(gate_bit_i) == GATE_INV));

    // R4: never routed while auto-suppress and processor reset coincide
    assert_auto_block_R4: assert property (@(posedge clk) disable iff (!por_n)
        rst_o |-> !$past(auto_bit_i && cpu_rst_i));

    // R7: the status bit is set whenever the routed reset is high
    assert_sticky_R7: assert property (@(posedge clk) disable iff (!por_n)
        rst_o |-> stat_o);

    // R8: the status bit only falls after a clearing write
    assert_clear_only_R8: assert property (@(posedge clk) disable iff (!por_n)
        $fell(stat_o) |-> $past(clr_i));

endmodule

// File: rtl/wdt_reset_router.sv
module wdt_reset_router #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 3,
    parameter int unsigned GATE_BIT = 8,
    parameter int unsigned AUTO_BIT = 8,
    parameter int unsigned CNT_BIT  = 4,
    parameter int unsigned STAT_BIT = 23,
    parameter bit          GATE_INV = 1'b0
) (
    input  logic                clk,
    input  logic                por_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W/8-1:0] bus_be,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic                wdt_req,
    input  logic                cpu_in_reset,
    output logic                cnt_enable,
    output logic                sys_wdt_rst
);

    logic gate_bit;
    logic auto_bit;
    logic stat_clr;
    logic stat_bit;

    wdr_regfile #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .GATE_BIT (GATE_BIT),
        .AUTO_BIT (AUTO_BIT),
        .CNT_BIT  (CNT_BIT),
        .STAT_BIT (STAT_BIT),
        .GATE_INV (GATE_INV)
    ) u_regs (
        .clk        (clk),
        .por_n      (por_n),
        .sel_i      (bus_sel),
        .wr_i       (bus_wr),
        .addr_i     (bus_addr),
        .be_i       (bus_be),
        .wdata_i    (bus_wdata),
        .stat_i     (stat_bit),
        .rdata_o    (bus_rdata),
        .gate_bit_o (gate_bit),
        .auto_bit_o (auto_bit),
        .cnt_o      (cnt_enable),
        .clr_o      (stat_clr)
    );

    wdr_gate #(
        .GATE_INV (GATE_INV)
    ) u_gate (
        .clk        (clk),
        .por_n      (por_n),
        .req_i      (wdt_req),
        .cpu_rst_i  (cpu_in_reset),
        .gate_bit_i (gate_bit),
        .auto_bit_i (auto_bit),
        .clr_i      (stat_clr),
        .rst_o      (sys_wdt_rst),
        .stat_o     (stat_bit)
    );

endmodule

// File: tb/tb_wdt_reset_router.sv
module tb_wdt_reset_router;

    localparam int DW = 32;
    localparam int AW = 3;
    localparam logic [DW-1:0] GBIT = 32'h1 << 8;
    localparam logic [DW-1:0] SBIT = 32'h1 << 23;

    logic          clk = 1'b0;
    logic          por_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [3:0]    bus_be = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic          wdt_req = 1'b0;
    logic          cpu_in_reset = 1'b0;
    logic [DW-1:0] rdata_n, rdata_i;
    logic          cnt_n, cnt_i, rst_n_out, rst_i_out;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    wdt_reset_router #(.GATE_INV(1'b0)) dut (
        .clk(clk), .por_n(por_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(rdata_n), .wdt_req(wdt_req), .cpu_in_reset(cpu_in_reset),
        .cnt_enable(cnt_n), .sys_wdt_rst(rst_n_out));

    wdt_reset_router #(.GATE_INV(1'b1)) dut_inv (
        .clk(clk), .por_n(por_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(rdata_i), .wdt_req(wdt_req), .cpu_in_reset(cpu_in_reset),
        .cnt_enable(cnt_i), .sys_wdt_rst(rst_i_out));

    // scoreboard: expected read values per instance
    typedef struct {
        logic [DW-1:0] exp_n;
        logic [DW-1:0] exp_i;
    } item_t;
    item_t sb[$];
    string tags[$];
    logic  rd_flag = 1'b0;

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    always @(posedge clk) rd_flag <= bus_sel && !bus_wr;

    // monitor: pops one expected pair per completed read
    always @(negedge clk) begin
        if (rd_flag && por_n) begin
            if (sb.size() == 0) begin
                check("R11 unexpected read", 32'h1, 32'h0);
            end else begin
                item_t it;
                string tg;
                it = sb.pop_front();
                tg = tags.pop_front();
                check({tg, " normal"}, rdata_n, it.exp_n);
                check({tg, " inverted"}, rdata_i, it.exp_i);
            end
        end
    end

    task automatic bus_write(input logic [AW-1:0] a, input logic [3:0] be, input logic [DW-1:0] wd);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = wd;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, input logic [DW-1:0] en, input logic [DW-1:0] ei, input string tag);
        item_t it;
        it.exp_n = en; it.exp_i = ei;
        sb.push_back(it);
        tags.push_back(tag);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_req(input logic en, input logic ei, input string tag);
        wdt_req = 1'b1;
        @(negedge clk);
        check({tag, " route normal"}, {31'b0, rst_n_out}, {31'b0, en});
        check({tag, " route inverted"}, {31'b0, rst_i_out}, {31'b0, ei});
        wdt_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rst normal", {31'b0, rst_n_out}, 32'h0);
        check("R1 rst inverted", {31'b0, rst_i_out}, 32'h0);
        check("R1 cnt normal", {31'b0, cnt_n}, 32'h0);
        check("R1 cnt inverted", {31'b0, cnt_i}, 32'h0);
        bus_read(3'd0, GBIT, 32'h0, "R1 gate reset");
        bus_read(3'd3, 32'h0, 32'h0, "R1 status reset");
        // R11 held read data
        check("R11 hold normal", rdata_n, 32'h0);

        // R2/R3 reset gating blocks both
        pulse_req(1'b0, 1'b0, "R2 blocked at reset");

        // R2/R3 gating bit cleared: normal passes, inverted blocks
        bus_write(3'd0, 4'hF, 32'hA5A5_0000);
        pulse_req(1'b1, 1'b0, "R2 R3 bit clear");
        bus_read(3'd0, 32'hA5A5_0000, 32'hA5A5_0000, "R6 full write");
        bus_read(3'd3, SBIT, 32'h0, "R7 status sticky");

        // R6 byte write sets bits 15:8 only; R3 inverted now passes
        bus_write(3'd0, 4'b0010, 32'hFFFF_FFFF);
        bus_read(3'd0, 32'hA5A5_FF00, 32'hA5A5_FF00, "R6 byte write");
        pulse_req(1'b0, 1'b1, "R3 bit set");
        bus_read(3'd3, SBIT, SBIT, "R7 status both");

        // R8 clear qualification
        bus_write(3'd3, 4'b1011, 32'hFFFF_FFFF);
        bus_read(3'd3, SBIT, SBIT, "R8 byte disabled");
        bus_write(3'd3, 4'hF, 32'h0);
        bus_read(3'd3, SBIT, SBIT, "R8 zero write");
        bus_write(3'd3, 4'b0100, SBIT);
        bus_read(3'd3, 32'h0, 32'h0, "R8 clear");

        // R4 auto-suppress (normal instance passes, inverted blocked)
        bus_write(3'd0, 4'b0010, 32'h0);
        bus_write(3'd1, 4'hF, GBIT);
        cpu_in_reset = 1'b1;
        pulse_req(1'b0, 1'b0, "R4 suppressed");
        bus_read(3'd3, 32'h0, 32'h0, "R4 no status");
        cpu_in_reset = 1'b0;
        pulse_req(1'b1, 1'b0, "R4 cpu running");
        bus_write(3'd1, 4'hF, 32'h0);
        cpu_in_reset = 1'b1;
        pulse_req(1'b1, 1'b0, "R4 auto off");
        cpu_in_reset = 1'b0;

        // R5 counter-run output
        bus_write(3'd2, 4'hF, 32'h10);
        check("R5 cnt set normal", {31'b0, cnt_n}, 32'h1);
        check("R5 cnt set inverted", {31'b0, cnt_i}, 32'h1);
        bus_write(3'd2, 4'b1110, 32'h0);
        check("R6 cnt other bytes", {31'b0, cnt_n}, 32'h1);
        bus_write(3'd2, 4'b0001, 32'h0);
        check("R5 cnt clear", {31'b0, cnt_n}, 32'h0);

        // R9 set wins over simultaneous clear (normal passes, inverted blocked)
        wdt_req = 1'b1;
        bus_write(3'd3, 4'hF, SBIT);
        wdt_req = 1'b0;
        bus_read(3'd3, SBIT, 32'h0, "R9 set over clear");

        // R10 unmapped index
        bus_write(3'd4, 4'hF, 32'hFFFF_FFFF);
        bus_read(3'd4, 32'h0, 32'h0, "R10 unmapped read");
        bus_read(3'd0, 32'hA5A5_0000, 32'hA5A5_0000, "R10 gate untouched");
        bus_read(3'd2, 32'h0, 32'h0, "R10 cnt untouched");

        // R1 power-on reset clears status and restores gating
        por_n = 1'b0;
        @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        bus_read(3'd3, 32'h0, 32'h0, "R1 status after por");
        bus_read(3'd0, GBIT, 32'h0, "R1 gate after por");

        repeat (3) @(negedge clk);
        if (sb.size() != 0) check("R11 reads pending", 32'(sb.size()), 32'h0);
        finish_run();
    end

endmodule